// File: doc/BRIEF.md
# Input Transition Counting Detector

The block watches one single-bit input on a clock and counts how many times its sampled value has changed. The count covers changes in both directions. When `K` changes have been counted, the output goes high and stays high until the next reset. It is meant for places where a line has to show real activity before anything downstream is armed. Examples are waiting for a line to toggle a set number of times, or for a handshake wire to go through a full high-then-low cycle.

The input is compared with the value the block sampled at the previous clock edge, and any difference counts as one transition. A rising edge followed at once by a falling edge is never merged into one event. The progress is held as a `K`-bit thermometer code, which gives `K+1` distinct states. Each counted transition moves the state up by one position. The top bit of the code is the output. For `K = 2` the state pair (top, bottom) runs (0,0), then (0,1), then (1,1). The input is assumed to be already synchronous to `clk` and free of bounce. `K` must be at least 1.

Top module: `trans_count_latch`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, `trigOut` is 0 and the count is zero.
- R2: A transition is counted at a rising edge of `clk` when `sigIn` differs from its value at the previous rising edge. The reference value after reset is 0, so an input held high through reset counts one transition at the first edge.
- R3: A falling change of `sigIn` counts exactly like a rising one.
- R4: While fewer than `K` transitions have been counted, `trigOut` is 0.
- R5: `trigOut` becomes 1 right after the clock edge that counts the `K`-th transition. It is therefore visible in the cycle that follows that edge.
- R6: Once `trigOut` is 1, it stays 1 until reset, whatever `sigIn` does.
- R7: Cycles in which `sigIn` holds its value leave the count unchanged.
- R8: Changes of `sigIn` in consecutive cycles, such as a one-cycle pulse, are each counted as a separate transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sigIn | input | 1 | Monitored input, synchronous to `clk` |
| trigOut | output | 1 | Goes high and stays high once `K` transitions are counted |

## Verification
Two functions can meet in the same cycle: the count advancing on a fresh transition, and saturation, where a count that has already reached `K` must ignore a new transition. The sweep toggles the input with gaps of zero, one and two idle cycles, for 0 to 7 toggles. With a zero gap, the transition right after the `K`-th one is sampled at the very edge where saturation first applies. A one-cycle pulse also makes two opposite changes land on back-to-back edges. Two instances, with `K` of 2 and of 5, get the same stimulus. After every clock, each output is compared with the arithmetic rule "toggles so far ≥ K".

// File: rtl/tcl_pkg.sv
package tcl_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // load the reference sample
    logic advance;  // move the thermometer one step
  } tcl_strobe_t;
endpackage

// File: rtl/tcl_datapath.sv
module tcl_datapath
  import tcl_pkg::*;
#(
  parameter int K = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sigIn,
  input  tcl_strobe_t strobes,
  output logic        edgeSeen,
  output logic        full,
  output logic        trigOut
);
  localparam logic [K-1:0] ONE = K'(1);

  logic         prevQ;
  logic [K-1:0] thermQ;

  // Reference sample; reset value 0 stands for an idle-low input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                prevQ <= 1'b0;
    else if (strobes.capture) prevQ <= sigIn;
  end

  assign edgeSeen = sigIn ^ prevQ;

  generate
    if (K == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                thermQ <= '0;
        else if (strobes.advance) thermQ <= 1'b1;
      end
    end else begin : g_therm
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                thermQ <= '0;
        else if (strobes.advance) thermQ <= {thermQ[K-2:0], 1'b1};
      end
    end
  endgenerate

  assign full    = thermQ[K-1];
  assign trigOut = thermQ[K-1];

  // R5
  therm_shape_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((thermQ + ONE) & thermQ) == '0);

  // R5
  step_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> $countones(thermQ) == $past($countones(thermQ)) + 1);

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.advance |=> $stable(thermQ));

  // R6
  out_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |=> trigOut);
endmodule

// File: rtl/tcl_control.sv
module tcl_control
  import tcl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        edgeSeen,
  input  logic        full,
  output tcl_strobe_t strobes
);
  always_comb begin
    strobes.capture = edgeSeen;
    strobes.advance = edgeSeen & ~full;
  end

  // R5
  rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(full) |-> $past(edgeSeen));

  // R6
  no_advance_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !strobes.advance);
endmodule

// File: rtl/trans_count_latch.sv
module trans_count_latch
  import tcl_pkg::*;
#(
  parameter int K = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  output logic trigOut
);
  tcl_strobe_t strobes;
  logic        edgeSeen;
  logic        full;

  tcl_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .edgeSeen (edgeSeen),
    .full     (full),
    .strobes  (strobes)
  );

  tcl_datapath #(.K(K)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sigIn    (sigIn),
    .strobes  (strobes),
    .edgeSeen (edgeSeen),
    .full     (full),
    .trigOut  (trigOut)
  );
endmodule

// File: tb/trans_count_latch_test.sv
module trans_count_latch_test;
  localparam int KA = 2;
  localparam int KB = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sigIn = 1'b0;
  logic outA, outB;
  int   checks = 0;
  int   errors = 0;
  int   toggles = 0;

  always #5 clk = ~clk;

  trans_count_latch #(.K(KA)) uut     (.clk(clk), .rstN(rstN), .sigIn(sigIn), .trigOut(outA));
  trans_count_latch #(.K(KB)) uutWide (.clk(clk), .rstN(rstN), .sigIn(sigIn), .trigOut(outB));

  function automatic string tagFor(int k);
    if (toggles < k)       return "R4";
    else if (toggles == k) return "R5";
    else                   return "R6";
  endfunction

  task automatic chk(string req, string who, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s toggles=%0d actual=%0b expected=%0b", req, who, toggles, act, exp);
    end
  endtask

  task automatic checkBoth(string reqOverride);
    string ra, rb;
    ra = (reqOverride != "") ? reqOverride : tagFor(KA);
    rb = (reqOverride != "") ? reqOverride : tagFor(KB);
    chk(ra, "K2", outA, logic'(toggles >= KA));
    chk(rb, "K5", outB, logic'(toggles >= KB));
  endtask

  // Called at a negedge: optionally toggle, then check after the next posedge
  task automatic cycle(bit tog, string req);
    if (tog) begin
      sigIn = ~sigIn;
      toggles++;
    end
    @(negedge clk);
    checkBoth(req);
  endtask

  task automatic doReset(logic level);
    rstN = 1'b0;
    sigIn = level;
    toggles = 0;
    repeat (2) @(negedge clk);
    checkBoth("R1");
    rstN = 1'b1;
    // R2: a high level is compared with the reset reference of 0
    if (level) toggles = 1;
    @(negedge clk);
    checkBoth(level ? "R2" : "R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R2 and R3: high through reset counts once, then a falling change reaches K=2
    doReset(1'b1);
    cycle(1'b1, "R3");
    cycle(1'b0, "R6");

    // R8: one-cycle pulse counts as two transitions
    doReset(1'b0);
    cycle(1'b1, "R8");
    cycle(1'b1, "R8");
    cycle(1'b0, "R6");

    // Sweep over toggle counts and gaps
    for (int n = 0; n < 8; n++) begin
      for (int g = 0; g < 3; g++) begin
        doReset(1'b0);
        for (int t = 0; t < n; t++) begin
          cycle(1'b1, "");
          for (int s = 0; s < (g + t) % 3; s++) cycle(1'b0, "R7");
        end
        repeat (4) cycle(1'b0, "R7");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule